// File: doc/BRIEF.md
# Triggered Sample-Store Pipeline Controller

This block runs the addressing of a circular analog sample store. Every clock one fresh sample lands in the cell named by the write address. The samples then wait there for the level-1 trigger decision, which arrives a fixed, programmable number of cycles later. When an accept arrives, the block works back from the current write address by that latency to find the first triggered cell. It queues a readout of a short run of consecutive cells starting there and stamps the readout with the bunch-crossing count and the event count that were current at the accept.

Queued cells are locked. The write address jumps over any locked cell, so waiting samples are never overwritten while new ones keep arriving. The digitizer walks the head readout one cell at a time and acknowledges each cell with a done strobe. Each acknowledged cell is released. After the last cell of a readout, the next queued readout is presented. Two strobes clear the counters: one clears the bunch counter and the other clears the event counter. An accept that finds the queue full is discarded and reported on a one-cycle overflow pulse.

Top module: `sca_pipeline_ctrl`

## Requirements
- R1: After reset the write address moves to a different cell on every clock. With no cell locked, it steps by one modulo DEPTH (default 144).
- R2: The write address moves to the first unlocked cell after the current one, and it never names a locked cell.
- R3: An accepted trigger queues a readout whose first cell is (write address − latency) modulo DEPTH. The latency input is held between 1 and MAX_LAT (default 100).
- R4: Every accept locks NSAMP (default 5) consecutive cells, counted upward modulo DEPTH from the first cell. A locked cell stays locked until the done strobe for that cell arrives.
- R5: read_valid is high whenever at least one readout is queued. read_addr is the first cell of the head readout plus the number of done strobes already taken for it. After the NSAMP-th done strobe, the next queued readout is presented on the following cycle, in accept order.
- R6: The queue holds QDEPTH (default 8) readouts. An accept that arrives while the queue is full is dropped, and overflow is high for exactly the following cycle.
- R7: The bunch counter advances by one every clock and wraps at 2^BCID_W. A bunch-reset strobe makes it zero on the next cycle.
- R8: The event counter advances by one on every accept, including a dropped one, and wraps at 2^EVID_W. An event-reset strobe makes it zero on the next cycle and takes priority over an accept in the same cycle.
- R9: bunch_id and event_id of the presented readout equal the counter values in the cycle of its accept.
- R10: While reset is held, write address, both counters, read_valid and overflow are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_accept | input | 1 | Level-1 accept strobe |
| bc_reset | input | 1 | Clears the bunch counter |
| ev_reset | input | 1 | Clears the event counter |
| latency | input | $clog2(MAX_LAT+1) | Trigger latency in cycles |
| rd_done | input | 1 | Digitizer finished the presented cell |
| wr_addr | output | $clog2(DEPTH) | Cell written this cycle |
| rd_addr | output | $clog2(DEPTH) | Cell to digitize |
| rd_valid | output | 1 | rd_addr and the tags are meaningful |
| bunch_id | output | BCID_W | Bunch count captured at the accept |
| event_id | output | EVID_W | Event count captured at the accept |
| overflow | output | 1 | One-cycle pulse after a dropped accept |

## Verification
The assertions rely on three things about the inputs. The latency input stays within 1..MAX_LAT. rd_done matters only while read_valid is high. DEPTH is larger than NSAMP·(QDEPTH+1), so the write address always finds a free cell within its search window. The bench meets these conditions by construction. It sweeps latency values only across the legal range, and it shrinks the store to 24 cells with a 4-entry queue of 3-cell readouts. That configuration keeps the arithmetic bound satisfied while still forcing frequent wraparound, lock skipping, queue overflow and counter wrap.

// File: rtl/sca_pipe_pkg.sv
// Shared modular-arithmetic helpers for the sample-store pipeline controller.
// Assumes both operands already lie in 0..m-1.
package sca_pipe_pkg;

    // (a + b) mod m for small non-negative operands
    function automatic int wrap_add(input int a, input int b, input int m);
        return (a + b) % m;
    endfunction

    // (a - b) mod m for operands in 0..m-1
    function automatic int wrap_sub(input int a, input int b, input int m);
        return (a - b + m) % m;
    endfunction

endpackage

// File: rtl/sca_tag_counters.sv
// Bunch-crossing and event counters used to tag each readout.
// The bunch counter free-runs once per clock and the event counter counts
// accepts. Each counter has its own clearing strobe, and the clear wins over
// counting. Assumes strobes are synchronous to clk.
module sca_tag_counters #(
    parameter int BCID_W = 12,
    parameter int EVID_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              bc_reset,
    input  logic              ev_reset,
    output logic [BCID_W-1:0] bunch_cnt,
    output logic [EVID_W-1:0] event_cnt
);

    // bunch counter: clear on strobe, else count every cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        bunch_cnt <= '0;
        else if (bc_reset) bunch_cnt <= '0;
        else               bunch_cnt <= bunch_cnt + 1'b1;
    end

    // event counter: clear on strobe, else count accepts
    always_ff @(posedge clk) begin
        if (!rst_n)        event_cnt <= '0;
        else if (ev_reset) event_cnt <= '0;
        else if (trig)     event_cnt <= event_cnt + 1'b1;
    end

    a_r7_bc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bc_reset |=> bunch_cnt == '0);
    a_r7_bc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !bc_reset |=> bunch_cnt == BCID_W'($past(bunch_cnt) + 1'b1));
    a_r8_ev_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ev_reset |=> event_cnt == '0);
    a_r8_ev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_reset && !trig) |=> $stable(event_cnt));

endmodule

// File: rtl/sca_write_ptr.sv
// Write address generator for the circular sample store.
// Each cycle it moves to the first cell after the current one that is not
// locked in the coming cycle. The search covers SKIP cells ahead. Assumes
// fewer than SKIP cells can be locked at once, so a free cell always exists.
module sca_write_ptr #(
    parameter int DEPTH = 144,
    parameter int SKIP  = 46,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] lock_now,
    input  logic [DEPTH-1:0] lock_next,
    output logic [AW-1:0]    wr_addr
);
    import sca_pipe_pkg::*;

    logic [AW-1:0] nxt_addr;

    // search forward for the nearest cell that will be free next cycle
    always_comb begin
        logic found;
        found    = 1'b0;
        nxt_addr = wr_addr;
        for (int i = 1; i <= SKIP; i++) begin
            logic [AW-1:0] cand;
            cand = AW'(wrap_add(int'(wr_addr), i, DEPTH));
            if (!found && !lock_next[cand]) begin
                nxt_addr = cand;
                found    = 1'b1;
            end
        end
    end

    // address register
    always_ff @(posedge clk) begin
        if (!rst_n) wr_addr <= '0;
        else        wr_addr <= nxt_addr;
    end

    a_r2_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_now[wr_addr]);
    a_r1_always_moves: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> wr_addr != $past(wr_addr));
    a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_addr) < DEPTH);

endmodule

// File: rtl/sca_trig_queue.sv
// Pending-readout queue with per-cell lock map.
// Each entry holds the first cell of a readout and the two tags. The head
// entry is presented cell by cell and advances on rd_done. lock_now covers
// the cells still owed by queued entries. lock_next also covers the entry
// being pushed this cycle. Assumes latency within 1..MAX_LAT and
// NSAMP >= 2.
module sca_trig_queue #(
    parameter int DEPTH   = 144,
    parameter int MAX_LAT = 100,
    parameter int NSAMP   = 5,
    parameter int QDEPTH  = 8,
    parameter int BCID_W  = 12,
    parameter int EVID_W  = 24,
    localparam int AW     = $clog2(DEPTH),
    localparam int LW     = $clog2(MAX_LAT + 1),
    localparam int QW     = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int CW     = $clog2(QDEPTH + 1),
    localparam int IW     = $clog2(NSAMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [LW-1:0]     latency,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BCID_W-1:0] bunch_cnt,
    input  logic [EVID_W-1:0] event_cnt,
    input  logic              rd_done,
    output logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [BCID_W-1:0] bunch_id,
    output logic [EVID_W-1:0] event_id,
    output logic              overflow,
    output logic [DEPTH-1:0]  lock_now,
    output logic [DEPTH-1:0]  lock_next
);
    import sca_pipe_pkg::*;

    logic [AW-1:0]     st_cell [QDEPTH];
    logic [BCID_W-1:0] st_bid  [QDEPTH];
    logic [EVID_W-1:0] st_eid  [QDEPTH];
    logic [QW-1:0]     head;
    logic [CW-1:0]     count;
    logic [IW-1:0]     rd_idx;

    logic          full, push, pop, step;
    logic [QW-1:0] tail;
    logic [AW-1:0] push_cell;

    // queue control decode
    always_comb begin
        full      = (count == CW'(QDEPTH));
        push      = trig && !full;
        rd_valid  = (count != '0);
        step      = rd_valid && rd_done;
        pop       = step && (rd_idx == IW'(NSAMP - 1));
        tail      = QW'((int'(head) + int'(count)) % QDEPTH);
        push_cell = AW'(wrap_sub(int'(wr_addr), int'(latency), DEPTH));
    end

    // entry storage: capture first cell and tags on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < QDEPTH; s++) begin
                st_cell[s] <= '0;
                st_bid[s]  <= '0;
                st_eid[s]  <= '0;
            end
        end else if (push) begin
            st_cell[tail] <= push_cell;
            st_bid[tail]  <= bunch_cnt;
            st_eid[tail]  <= event_cnt;
        end
    end

    // head, occupancy and cell index within the head readout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head   <= '0;
            count  <= '0;
            rd_idx <= '0;
        end else begin
            if (pop) begin
                head   <= QW'((int'(head) + 1) % QDEPTH);
                rd_idx <= '0;
            end else if (step) begin
                rd_idx <= rd_idx + 1'b1;
            end
            count <= CW'(int'(count) + int'(push) - int'(pop));
        end
    end

    // one-cycle overflow pulse after a dropped accept
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else        overflow <= trig && full;
    end

    // lock map from queued entries, plus the entry being pushed
    always_comb begin
        for (int c = 0; c < DEPTH; c++) begin
            logic hit;
            hit = 1'b0;
            for (int s = 0; s < QDEPTH; s++) begin
                int rel, off, lo;
                rel = (s - int'(head) + QDEPTH) % QDEPTH;
                off = wrap_sub(c, int'(st_cell[s]), DEPTH);
                lo  = (s == int'(head)) ? int'(rd_idx) : 0;
                if (rel < int'(count) && off < NSAMP && off >= lo) hit = 1'b1;
            end
            lock_now[c]  = hit;
            lock_next[c] = hit ||
                (push && wrap_sub(c, int'(push_cell), DEPTH) < NSAMP);
        end
    end

    // present head readout
    always_comb begin
        rd_addr  = AW'(wrap_add(int'(st_cell[head]), int'(rd_idx), DEPTH));
        bunch_id = st_bid[head];
        event_id = st_eid[head];
    end

    a_r3_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
        latency >= LW'(1) && int'(latency) <= MAX_LAT);
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= QDEPTH);
    a_r6_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && count == CW'(QDEPTH)) |=> overflow);
    a_r6_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && count == CW'(QDEPTH) && !rd_done) |=> count == CW'(QDEPTH));
    a_r4_read_cell_locked: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> lock_now[rd_addr]);
    a_r5_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_done) |=> $stable(rd_addr));

endmodule

// File: rtl/sca_pipeline_ctrl.sv
// Top of the triggered sample-store pipeline controller.
// It wires the tag counters, the pending-readout queue with its lock map and
// the write address generator. Assumes DEPTH > NSAMP*(QDEPTH+1) and
// MAX_LAT < DEPTH.
module sca_pipeline_ctrl #(
    parameter int DEPTH   = 144,
    parameter int MAX_LAT = 100,
    parameter int NSAMP   = 5,
    parameter int QDEPTH  = 8,
    parameter int BCID_W  = 12,
    parameter int EVID_W  = 24,
    localparam int AW     = $clog2(DEPTH),
    localparam int LW     = $clog2(MAX_LAT + 1),
    localparam int SKIP   = NSAMP * (QDEPTH + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_accept,
    input  logic              bc_reset,
    input  logic              ev_reset,
    input  logic [LW-1:0]     latency,
    input  logic              rd_done,
    output logic [AW-1:0]     wr_addr,
    output logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [BCID_W-1:0] bunch_id,
    output logic [EVID_W-1:0] event_id,
    output logic              overflow
);

    logic [BCID_W-1:0] bunch_cnt;
    logic [EVID_W-1:0] event_cnt;
    logic [DEPTH-1:0]  lock_now;
    logic [DEPTH-1:0]  lock_next;

    sca_tag_counters #(
        .BCID_W (BCID_W),
        .EVID_W (EVID_W)
    ) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig_accept),
        .bc_reset  (bc_reset),
        .ev_reset  (ev_reset),
        .bunch_cnt (bunch_cnt),
        .event_cnt (event_cnt)
    );

    sca_trig_queue #(
        .DEPTH   (DEPTH),
        .MAX_LAT (MAX_LAT),
        .NSAMP   (NSAMP),
        .QDEPTH  (QDEPTH),
        .BCID_W  (BCID_W),
        .EVID_W  (EVID_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig_accept),
        .latency   (latency),
        .wr_addr   (wr_addr),
        .bunch_cnt (bunch_cnt),
        .event_cnt (event_cnt),
        .rd_done   (rd_done),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .bunch_id  (bunch_id),
        .event_id  (event_id),
        .overflow  (overflow),
        .lock_now  (lock_now),
        .lock_next (lock_next)
    );

    sca_write_ptr #(
        .DEPTH (DEPTH),
        .SKIP  (SKIP)
    ) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_now  (lock_now),
        .lock_next (lock_next),
        .wr_addr   (wr_addr)
    );

    a_r10_reset_idle: assert property (@(posedge clk)
        !$past(rst_n) && $past(rst_n, 2) == 1'b0 |-> (!rd_valid && !overflow));

endmodule

// File: tb/sca_pipeline_ctrl_test.sv
// Self-checking bench: a small store (24 cells, 3-cell readouts, 4-entry
// queue) driven through latency sweeps, overflow, counter clears and a long
// mixed pattern, against an arithmetic model of the requirements.
module sca_pipeline_ctrl_test;
    localparam int D  = 24;
    localparam int ML = 12;
    localparam int N  = 3;
    localparam int Q  = 4;
    localparam int BW = 4;
    localparam int EW = 6;
    localparam int AW = $clog2(D);
    localparam int LW = $clog2(ML + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_accept = 1'b0, bc_reset = 1'b0, ev_reset = 1'b0, rd_done = 1'b0;
    logic [LW-1:0] latency = LW'(1);
    logic [AW-1:0] wr_addr, rd_addr;
    logic          rd_valid, overflow;
    logic [BW-1:0] bunch_id;
    logic [EW-1:0] event_id;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // model state
    int m_wp, m_bc, m_ev, m_head, m_cnt, m_idx;
    bit m_ovf;
    int m_start [Q];
    int m_bid [Q];
    int m_eid [Q];

    always #10 clk = ~clk;

    sca_pipeline_ctrl #(
        .DEPTH (D), .MAX_LAT (ML), .NSAMP (N), .QDEPTH (Q),
        .BCID_W (BW), .EVID_W (EW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .trig_accept (trig_accept),
        .bc_reset (bc_reset), .ev_reset (ev_reset), .latency (latency),
        .rd_done (rd_done), .wr_addr (wr_addr), .rd_addr (rd_addr),
        .rd_valid (rd_valid), .bunch_id (bunch_id), .event_id (event_id),
        .overflow (overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mlocked(input int c, input bit with_push, input int pstart);
        for (int s = 0; s < Q; s++) begin
            int rel, off, lo;
            rel = (s - m_head + Q) % Q;
            off = (c - m_start[s] + D) % D;
            lo  = (s == m_head) ? m_idx : 0;
            if (rel < m_cnt && off < N && off >= lo) return 1'b1;
        end
        if (with_push && ((c - pstart + D) % D) < N) return 1'b1;
        return 1'b0;
    endfunction

    task automatic compare();
        chk("R1 R2 R4 wr_addr", int'(wr_addr), m_wp);
        chk("R5 rd_valid", int'(rd_valid), int'(m_cnt != 0));
        chk("R6 overflow", int'(overflow), int'(m_ovf));
        if (m_cnt != 0) begin
            chk("R3 R5 rd_addr", int'(rd_addr), (m_start[m_head] + m_idx) % D);
            chk("R7 R9 bunch_id", int'(bunch_id), m_bid[m_head]);
            chk("R8 R9 event_id", int'(event_id), m_eid[m_head]);
        end
    endtask

    // one clock: drive, let the edge pass, advance the model, check at negedge
    task automatic tick(input bit t, input bit b, input bit e, input bit d);
        int pstart, nwp, tl;
        bit push, pop;
        trig_accept = t; bc_reset = b; ev_reset = e; rd_done = d;
        @(posedge clk);
        push   = t && (m_cnt < Q);
        pop    = (m_cnt > 0) && d && (m_idx == N - 1);
        pstart = (m_wp - int'(latency) + D) % D;
        nwp    = m_wp;
        for (int i = 1; i < D; i++) begin
            int c;
            c = (m_wp + i) % D;
            if (!mlocked(c, push, pstart)) begin
                nwp = c;
                break;
            end
        end
        tl = (m_head + m_cnt) % Q;
        if (push) begin
            m_start[tl] = pstart;
            m_bid[tl]   = m_bc;
            m_eid[tl]   = m_ev;
        end
        if (pop) begin
            m_head = (m_head + 1) % Q;
            m_idx  = 0;
        end else if (d && m_cnt > 0) begin
            m_idx++;
        end
        m_cnt = m_cnt + int'(push) - int'(pop);
        m_ovf = t && !push;
        m_wp  = nwp;
        m_bc  = b ? 0 : (m_bc + 1) % (1 << BW);
        m_ev  = e ? 0 : (t ? (m_ev + 1) % (1 << EW) : m_ev);
        @(negedge clk);
        compare();
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (m_cnt != 0 && guard < 200) begin
            tick(1'b0, 1'b0, 1'b0, 1'b1);
            guard++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_wp = 0; m_bc = 0; m_ev = 0; m_head = 0; m_cnt = 0; m_idx = 0; m_ovf = 0;
        for (int s = 0; s < Q; s++) begin
            m_start[s] = 0; m_bid[s] = 0; m_eid[s] = 0;
        end
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 wr_addr", int'(wr_addr), 0);
        chk("R10 rd_valid", int'(rd_valid), 0);
        chk("R10 overflow", int'(overflow), 0);
        rst_n = 1'b1;

        // first accept right after reset sees zeroed counters (R10)
        latency = LW'(1);
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 event_id after reset", int'(event_id), 0);
        chk("R10 bunch_id after reset", int'(bunch_id), 0);
        drain();

        // R3 latency sweep across the legal range
        for (int lat = 1; lat <= ML; lat++) begin
            latency = LW'(lat);
            repeat (lat + 2) tick(1'b0, 1'b0, 1'b0, 1'b0);
            tick(1'b1, 1'b0, 1'b0, 1'b0);
            tick(1'b0, 1'b0, 1'b0, 1'b0);
            drain();
        end

        // R6 overflow: fill the queue and keep accepting
        latency = LW'(6);
        for (int k = 0; k < Q + 3; k++) tick(1'b1, 1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        drain();

        // R7 R8: clears coinciding with accepts
        latency = LW'(4);
        tick(1'b1, 1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        drain();

        // long mixed pattern: wraparound, skipping, counter wrap
        for (int k = 0; k < 3000; k++) begin
            bit t, b, e, d;
            if (k % 50 == 0) latency = LW'(1 + (k / 50) % ML);
            t = (k % 7 == 0) || (k % 11 == 3);
            b = (k % 97 == 50);
            e = (k % 131 == 60);
            d = (k % 3 != 0);
            tick(t, b, e, d);
        end
        drain();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule